// File: doc/BRIEF.md
# Guarded Partition-Valid Control Register

This block holds one 64-bit control register and decides what happens to every read or write request aimed at it. The low 32 bits are per-entry valid flags for a table of partition-mapping entries. The high 32 bits are always zero. How many of the low bits exist depends on a 3-bit capability input that gives the number of four-entry groups minus one.

Each request arrives with the requester's privilege level (0 to 3). The block also sees feature and capability flags, a 3-bit nested-virtualization control field, a trap-lower flag owned by the highest level, a flag that says the highest level exists, and two secure-debug flags. From these it picks exactly one outcome in the same cycle:

- perform the access on the register;
- report an undefined instruction;
- report a trap to level 2 or level 3, with a syndrome class;
- redirect the access to a fixed memory slot.

The block only issues these requests. Taking the exception and moving the memory data are done elsewhere.

Top module: `sysreg_access_ctrl`

## Requirements
- R1: When both feature-revision flags are 0, or the hypervisor-control capability flag is 0, every request gets outcome undefined, whatever its level.
- R2: A request from level 0 gets outcome undefined.
- R3: At level 1, when nested-virtualization bit 2 and bit 0 are both set, the outcome is redirect. `mem_offset` then reads 0x938, `mem_write` copies `req_write`, and `mem_wdata` carries `req_wdata`. The register does not change.
- R4: At level 1, when bit 0 is set and bit 2 is clear, the request traps, with syndrome class 0x18 on `trap_class`. The target is level 3 (`trap_level` = 3) when the highest level exists and trap-lower is set. In that case the outcome is undefined instead if the secure-debug-undefined flag is set. In every other case the target is level 2 (`trap_level` = 2).
- R5: At level 1, when nested-virtualization bit 0 is clear, the outcome is undefined.
- R6: At level 2 the checks go in this order:
  1. If the highest level exists, the priority secure-debug flag is set and trap-lower is set, the outcome is undefined.
  2. Otherwise, if the highest level exists and trap-lower is set, the outcome is a trap to level 3, or undefined when the secure-debug-undefined flag is set.
  3. Otherwise the outcome is direct access.
- R7: At level 3, with the features present, the outcome is always direct access.
- R8: A direct read returns the valid flags zero-extended to 64 bits, so bits 63:32 read as zero. Writes to bits 63:32 are dropped.
- R9: Valid flag m is held at zero and ignores writes when m >= (cap_groups + 1) * 4. It reads as zero under the cap_groups value in force at the read.
- R10: Reset clears every valid flag to zero.
- R11: `out_valid` pulses in the same cycle as every request and never without one. `out_kind` codes the outcome: 0 direct, 1 undefined, 2 trap, 3 redirect. Only a direct write changes the register, and the change is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_level | input | 2 | Privilege level of the requester |
| feat_rev_a | input | 1 | First feature revision present |
| feat_rev_b | input | 1 | Second feature revision present |
| cap_hyp_ctl | input | 1 | Hypervisor-control capability present |
| cap_groups | input | 3 | Implemented four-entry groups minus one |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| top_trap_lower | input | 1 | Highest level traps lower-level accesses |
| top_present | input | 1 | Highest level (3) exists |
| sdbg_undef | input | 1 | Secure-debug: turn level-3 traps into undefined |
| sdbg_undef_prio | input | 1 | Secure-debug: undefined takes priority at level 2 |
| out_valid | output | 1 | Outcome strobe |
| out_kind | output | 2 | Outcome code |
| rd_data | output | 64 | Read data on a direct read, else zero |
| trap_level | output | 2 | Trap target level |
| trap_class | output | 6 | Trap syndrome class |
| mem_req | output | 1 | Redirect memory request |
| mem_write | output | 1 | Redirect direction |
| mem_offset | output | 16 | Redirect byte offset |
| mem_wdata | output | 64 | Redirect write data |

## Verification
Every outcome output (`out_valid`, `out_kind`, `trap_*`, `mem_*` and `rd_data`) is combinational and due in the same cycle as the request. A direct write lands on the register at the following rising edge, so its effect can first be seen in the next cycle. The bench drives each request on a falling edge and samples the outputs 2 ns later, before the next rising edge. It holds each request for one cycle and leaves an idle cycle after it, so every read-back of a write happens at least one edge later.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [1:0] {
        OC_DIRECT = 2'd0,
        OC_UNDEF  = 2'd1,
        OC_TRAP   = 2'd2,
        OC_REDIR  = 2'd3
    } outcome_e;

    typedef struct packed {
        outcome_e    kind;
        logic [1:0]  tgt_lvl;
    } verdict_t;

    typedef struct packed {
        logic       rev_a;
        logic       rev_b;
        logic       hyp_ctl;
        logic [2:0] nv;
        logic       trap_lower;
        logic       top_present;
        logic       sd_undef;
        logic       sd_undef_prio;
    } ctl_flags_t;

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_OS    = 2'd1;
    localparam logic [1:0] LVL_HYP   = 2'd2;
    localparam logic [1:0] LVL_MON   = 2'd3;

    function automatic verdict_t mk_verdict(outcome_e k, logic [1:0] l);
        verdict_t v;
        v.kind    = k;
        v.tgt_lvl = l;
        return v;
    endfunction

    // Trap toward the highest level, or undefined when secure debug forbids it.
    function automatic verdict_t top_trap(logic sd_undef);
        return sd_undef ? mk_verdict(OC_UNDEF, 2'd0) : mk_verdict(OC_TRAP, LVL_MON);
    endfunction

endpackage

// File: rtl/sra_decide.sv
module sra_decide
    import sra_pkg::*;
(
    input  logic [1:0] level,
    input  ctl_flags_t fl,
    output verdict_t   verdict
);
    logic feat_ok;
    logic top_claims;

    assign feat_ok    = (fl.rev_a | fl.rev_b) & fl.hyp_ctl;
    assign top_claims = fl.top_present & fl.trap_lower;

    always_comb begin
        verdict = mk_verdict(OC_UNDEF, 2'd0);
        if (feat_ok) begin
            unique case (level)
                LVL_USER: verdict = mk_verdict(OC_UNDEF, 2'd0);
                LVL_OS: begin
                    if (fl.nv[0] && fl.nv[2])
                        verdict = mk_verdict(OC_REDIR, 2'd0);
                    else if (fl.nv[0])
                        verdict = top_claims ? top_trap(fl.sd_undef)
                                             : mk_verdict(OC_TRAP, LVL_HYP);
                    else
                        verdict = mk_verdict(OC_UNDEF, 2'd0);
                end
                LVL_HYP: begin
                    if (top_claims && fl.sd_undef_prio)
                        verdict = mk_verdict(OC_UNDEF, 2'd0);
                    else if (top_claims)
                        verdict = top_trap(fl.sd_undef);
                    else
                        verdict = mk_verdict(OC_DIRECT, 2'd0);
                end
                default: verdict = mk_verdict(OC_DIRECT, 2'd0);
            endcase
        end
    end
endmodule

// File: rtl/sra_entry_mask.sv
module sra_entry_mask #(
    parameter int ENTRY_CNT = 32,
    parameter int GRP_SIZE  = 4,
    parameter int CAP_W     = 3
) (
    input  logic [CAP_W-1:0]     cap,
    output logic [ENTRY_CNT-1:0] mask
);
    localparam int NUM_GRP = ENTRY_CNT / GRP_SIZE;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic grp_on;
        assign grp_on = (int'(cap) >= g);
        assign mask[g*GRP_SIZE +: GRP_SIZE] = {GRP_SIZE{grp_on}};
    end
endmodule

// File: rtl/sra_valid_store.sv
module sra_valid_store #(
    parameter int ENTRY_CNT = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ENTRY_CNT-1:0] wr_bits,
    input  logic [ENTRY_CNT-1:0] wr_mask,
    output logic [ENTRY_CNT-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_bits & wr_mask;
    end
endmodule

// File: rtl/sysreg_access_ctrl.sv
module sysreg_access_ctrl
    import sra_pkg::*;
#(
    parameter int               REG_W      = 64,
    parameter int               ENTRY_CNT  = 32,
    parameter int               GRP_SIZE   = 4,
    parameter int               CAP_W      = 3,
    parameter int               OFS_W      = 16,
    parameter logic [15:0]      REDIR_OFS  = 16'h0938,
    parameter logic [5:0]       TRAP_CLASS = 6'h18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [REG_W-1:0] req_wdata,
    input  logic [1:0]       req_level,
    input  logic             feat_rev_a,
    input  logic             feat_rev_b,
    input  logic             cap_hyp_ctl,
    input  logic [CAP_W-1:0] cap_groups,
    input  logic [2:0]       nv_ctl,
    input  logic             top_trap_lower,
    input  logic             top_present,
    input  logic             sdbg_undef,
    input  logic             sdbg_undef_prio,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [REG_W-1:0] rd_data,
    output logic [1:0]       trap_level,
    output logic [5:0]       trap_class,
    output logic             mem_req,
    output logic             mem_write,
    output logic [OFS_W-1:0] mem_offset,
    output logic [REG_W-1:0] mem_wdata
);
    localparam int PAD_W = REG_W - ENTRY_CNT;

    ctl_flags_t             flags;
    verdict_t               verdict;
    logic [ENTRY_CNT-1:0]   live_mask;
    logic [ENTRY_CNT-1:0]   valid_q;
    logic                   is_direct;
    logic                   is_trap;
    logic                   is_redir;
    logic                   wr_en;

    always_comb begin
        flags.rev_a         = feat_rev_a;
        flags.rev_b         = feat_rev_b;
        flags.hyp_ctl       = cap_hyp_ctl;
        flags.nv            = nv_ctl;
        flags.trap_lower    = top_trap_lower;
        flags.top_present   = top_present;
        flags.sd_undef      = sdbg_undef;
        flags.sd_undef_prio = sdbg_undef_prio;
    end

    sra_decide u_decide (
        .level   (req_level),
        .fl      (flags),
        .verdict (verdict)
    );

    sra_entry_mask #(
        .ENTRY_CNT (ENTRY_CNT),
        .GRP_SIZE  (GRP_SIZE),
        .CAP_W     (CAP_W)
    ) u_mask (
        .cap  (cap_groups),
        .mask (live_mask)
    );

    assign is_direct = req_valid && (verdict.kind == OC_DIRECT);
    assign is_trap   = req_valid && (verdict.kind == OC_TRAP);
    assign is_redir  = req_valid && (verdict.kind == OC_REDIR);
    assign wr_en     = is_direct && req_write;

    sra_valid_store #(
        .ENTRY_CNT (ENTRY_CNT)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bits (req_wdata[ENTRY_CNT-1:0]),
        .wr_mask (live_mask),
        .q       (valid_q)
    );

    assign out_valid  = req_valid;
    assign out_kind   = req_valid ? verdict.kind : OC_DIRECT;
    assign rd_data    = (is_direct && !req_write)
                        ? {{PAD_W{1'b0}}, valid_q & live_mask} : '0;
    assign trap_level = is_trap ? verdict.tgt_lvl : 2'd0;
    assign trap_class = is_trap ? TRAP_CLASS : 6'd0;
    assign mem_req    = is_redir;
    assign mem_write  = is_redir && req_write;
    assign mem_offset = is_redir ? REDIR_OFS[OFS_W-1:0] : '0;
    assign mem_wdata  = (is_redir && req_write) ? req_wdata : '0;

endmodule

// File: rtl/sra_checker.sv
module sra_checker
    import sra_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_level,
    input logic        feat_rev_a,
    input logic        feat_rev_b,
    input logic        cap_hyp_ctl,
    input logic [2:0]  nv_ctl,
    input logic        top_trap_lower,
    input logic        top_present,
    input logic        sdbg_undef_prio,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic [63:0] rd_data,
    input logic [5:0]  trap_class,
    input logic [31:0] store_q
);
    logic feat_ok;
    assign feat_ok = (feat_rev_a | feat_rev_b) & cap_hyp_ctl;

    AST_NO_FEAT_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !feat_ok) |-> (out_kind == OC_UNDEF)); // R1
    AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd0) |-> (out_kind == OC_UNDEF)); // R2
    AST_REDIR_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == OC_REDIR) |-> (req_level == 2'd1 && nv_ctl[2] && nv_ctl[0])); // R3
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == OC_TRAP) |-> (trap_class == 6'h18)); // R4
    AST_L1_NV0_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd1 && !nv_ctl[0]) |-> (out_kind == OC_UNDEF)); // R5
    AST_L2_PRIO_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && feat_ok && req_level == 2'd2 && top_present && top_trap_lower && sdbg_undef_prio)
        |-> (out_kind == OC_UNDEF)); // R6
    AST_L3_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && feat_ok && req_level == 2'd3) |-> (out_kind == OC_DIRECT)); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rd_data[63:32] == 32'd0)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (store_q == 32'd0)); // R10
    AST_HOLD_NONWRITE: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_kind == OC_DIRECT && req_write) |=> $stable(store_q)); // R11
endmodule

bind sysreg_access_ctrl sra_checker chk_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_level       (req_level),
    .feat_rev_a      (feat_rev_a),
    .feat_rev_b      (feat_rev_b),
    .cap_hyp_ctl     (cap_hyp_ctl),
    .nv_ctl          (nv_ctl),
    .top_trap_lower  (top_trap_lower),
    .top_present     (top_present),
    .sdbg_undef_prio (sdbg_undef_prio),
    .out_valid       (out_valid),
    .out_kind        (out_kind),
    .rd_data         (rd_data),
    .trap_class      (trap_class),
    .store_q         (valid_q)
);

// File: tb/sysreg_access_ctrl_tb_top.sv
module sysreg_access_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_level = '0;
    logic        feat_rev_a = 1'b1;
    logic        feat_rev_b = 1'b0;
    logic        cap_hyp_ctl = 1'b1;
    logic [2:0]  cap_groups = 3'd7;
    logic [2:0]  nv_ctl = '0;
    logic        top_trap_lower = 1'b0;
    logic        top_present = 1'b0;
    logic        sdbg_undef = 1'b0;
    logic        sdbg_undef_prio = 1'b0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [63:0] rd_data;
    logic [1:0]  trap_level;
    logic [5:0]  trap_class;
    logic        mem_req;
    logic        mem_write;
    logic [15:0] mem_offset;
    logic [63:0] mem_wdata;

    always #4 clk = ~clk;

    sysreg_access_ctrl dut_i (.*);

    typedef struct {
        logic [1:0]  kind;
        logic [1:0]  lvl;
        logic        rd_chk;
        logic [63:0] rd;
        logic        wr;
        logic [63:0] wd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    logic [31:0] model = '0;
    bit    done = 0;

    function automatic logic [31:0] cap_mask(logic [2:0] c);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = ((i / 4) <= int'(c));
        return m;
    endfunction

    // Expected outcome from the requirement text: codes 0 direct, 1 undef, 2 trap, 3 redirect.
    function automatic exp_t predict(logic wr, logic [63:0] wd);
        exp_t e;
        logic claims;
        e.kind = 2'd1; e.lvl = 2'd0; e.rd_chk = 0; e.rd = '0; e.wr = 0; e.wd = '0;
        claims = top_present && top_trap_lower;
        if (!((feat_rev_a || feat_rev_b) && cap_hyp_ctl)) e.kind = 2'd1;          // R1
        else if (req_level == 2'd0) e.kind = 2'd1;                                 // R2
        else if (req_level == 2'd1) begin
            if (nv_ctl[2] && nv_ctl[0]) begin e.kind = 2'd3; e.wr = wr; e.wd = wr ? wd : '0; end // R3
            else if (nv_ctl[0]) begin                                               // R4
                if (claims) begin
                    if (sdbg_undef) e.kind = 2'd1; else begin e.kind = 2'd2; e.lvl = 2'd3; end
                end else begin e.kind = 2'd2; e.lvl = 2'd2; end
            end else e.kind = 2'd1;                                                 // R5
        end else if (req_level == 2'd2) begin                                       // R6
            if (claims && sdbg_undef_prio) e.kind = 2'd1;
            else if (claims) begin
                if (sdbg_undef) e.kind = 2'd1; else begin e.kind = 2'd2; e.lvl = 2'd3; end
            end else e.kind = 2'd0;
        end else e.kind = 2'd0;                                                     // R7
        if (e.kind == 2'd0 && !wr) begin
            e.rd_chk = 1;
            e.rd = {32'd0, model & cap_mask(cap_groups)};                           // R8 R9
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic issue(logic [1:0] lvl, logic wr, logic [63:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        req_level = lvl; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        e = predict(wr, wd);
        if (e.kind == 2'd0 && wr) model = wd[31:0] & cap_mask(cap_groups);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic flags(logic tp, logic tl, logic sd, logic sdp);
        top_present = tp; top_trap_lower = tl; sdbg_undef = sd; sdbg_undef_prio = sdp;
    endtask

    // Monitor: samples 2 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R11", "unexpected out_valid", 64'(out_valid), 64'd0);
                    end else begin
                        exp_t e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_kind == e.kind, t, "out_kind", 64'(out_kind), 64'(e.kind));
                        if (e.kind == 2'd2) begin
                            check(trap_level == e.lvl, t, "trap_level", 64'(trap_level), 64'(e.lvl));
                            check(trap_class == 6'h18, t, "trap_class", 64'(trap_class), 64'h18);
                        end
                        if (e.kind == 2'd3) begin
                            check(mem_req && mem_offset == 16'h0938, t, "mem_offset", 64'(mem_offset), 64'h938);
                            check(mem_write == e.wr, t, "mem_write", 64'(mem_write), 64'(e.wr));
                            check(mem_wdata == e.wd, t, "mem_wdata", mem_wdata, e.wd);
                        end
                        if (e.rd_chk) check(rd_data == e.rd, t, "rd_data", rd_data, e.rd);
                    end
                end else if (exp_q.size() != 0) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                    check(0, "R11", "missing out_valid", 64'd0, 64'd1);
                end
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: flags read zero after reset
        issue(2'd3, 1'b0, '0, "R10");
        // R11: no pulse while idle
        @(negedge clk); #2;
        check(out_valid == 1'b0, "R11", "idle out_valid", 64'(out_valid), 64'd0);
        // R7 / R8: level 3 direct write and read back, upper half dropped
        issue(2'd3, 1'b1, 64'hFFFF_FFFF_1234_5678, "R7");
        issue(2'd3, 1'b0, '0, "R8");
        // R2: level 0 undefined
        issue(2'd0, 1'b0, '0, "R2");
        issue(2'd0, 1'b1, 64'h1, "R2");
        // R1: missing features
        feat_rev_a = 0; feat_rev_b = 0;
        issue(2'd3, 1'b1, 64'h5, "R1");
        feat_rev_b = 1; cap_hyp_ctl = 0;
        issue(2'd3, 1'b0, '0, "R1");
        cap_hyp_ctl = 1; feat_rev_a = 0;
        // R3: redirect at level 1
        nv_ctl = 3'b101;
        issue(2'd1, 1'b1, 64'hDEAD_BEEF_0000_00AA, "R3");
        nv_ctl = 3'b111;
        issue(2'd1, 1'b0, '0, "R3");
        // R4: traps at level 1
        nv_ctl = 3'b001;
        flags(1, 1, 0, 0); issue(2'd1, 1'b1, 64'hF0, "R4");
        flags(1, 1, 1, 0); issue(2'd1, 1'b0, '0, "R4");
        flags(0, 1, 1, 0); issue(2'd1, 1'b1, 64'h3, "R4");
        nv_ctl = 3'b011;
        flags(1, 0, 0, 0); issue(2'd1, 1'b0, '0, "R4");
        // R5: bit 0 clear
        nv_ctl = 3'b100;
        issue(2'd1, 1'b1, 64'h7, "R5");
        // R6: level 2 priority chain
        flags(1, 1, 0, 1); issue(2'd2, 1'b1, 64'h9, "R6");
        flags(1, 1, 0, 0); issue(2'd2, 1'b1, 64'h9, "R6");
        flags(1, 1, 1, 0); issue(2'd2, 1'b0, '0, "R6");
        flags(0, 1, 1, 1); issue(2'd2, 1'b0, '0, "R6");
        // R11: non-direct writes above left flags untouched
        flags(0, 0, 0, 0);
        issue(2'd2, 1'b0, '0, "R11");
        // R9: writes limited by group count
        cap_groups = 3'd1;
        issue(2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        cap_groups = 3'd7;
        issue(2'd3, 1'b0, '0, "R9");
        issue(2'd3, 1'b1, 64'hFFFF_FFFF, "R9");
        cap_groups = 3'd2;
        issue(2'd3, 1'b0, '0, "R9");
        cap_groups = 3'd7;
        issue(2'd3, 1'b0, '0, "R9");
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R11", "drained queue", 64'(exp_q.size()), 64'd0);
        finish_up();
    end

endmodule